// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block holds the configuration of a small bank of general-purpose pins and presents it to a pad model. Each pin owns two 32-bit words on a simple memory-mapped read/write bus. The control word selects the pin function, bias, drive-strength code and direction. The I/O word holds the output level and shows the synchronized input level. Software changes one field by reading the control word, editing it and writing the whole word back.

The pad side receives the following for every pin:
- output enable;
- output data, forced low while the pin is an input;
- function index;
- raw bias code, plus a decoded pull-up, pull-down or keeper request;
- drive code.

A drive code n stands for (n+1)*2 mA. A build option, `NO_KEEPER`, serves pad libraries that have no bus keeper. In that build, bias code 2 selects pull-up.

The bus address has two parts. Address bit 0 selects the word: 0 for the control word, 1 for the I/O word. The bits above it select the pin. A read returns its data one cycle after the request.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After synchronous reset, every pin has output enable 0, function 0 (plain GPIO), bias code 0, drive code 0 and output level 0. Every control word reads 0.
- R2: The control word places the function index at bits [FUNC_W-1:0], the bias code at [5:4], the drive code at [10:8] and output enable at bit 12. A write updates the matching pad outputs on the next clock, and a later read returns the written fields.
- R3: Writes to control-word bits outside those fields are ignored, and those bits read back as 0.
- R4: With `NO_KEEPER`=0, bias code 0 asserts none of pull-up, pull-down and keeper. Code 1 asserts pull-down, code 2 keeper and code 3 pull-up. At most one of the three is asserted.
- R5: With `NO_KEEPER`=1, bias codes 2 and 3 both assert pull-up, and keeper is never asserted.
- R6: The 3-bit drive code, meaning (code+1)*2 mA, reaches `pad_drive` unchanged for all eight codes.
- R7: When output enable is 0, `pad_oe` is 0 and `pad_out` is 0 whatever the output level is. When output enable is 1, `pad_out` follows the output level.
- R8: In the I/O word, bit 1 is the writable output level and bit 0 is the read-only input level. A write to bit 0 has no effect, and all other bits read 0.
- R9: `pad_in` passes through two flops. A change applied before clock edge k first appears in a read whose data is captured at edge k+2. Reads captured at edges k and k+1 still return the old level.
- R10: A write to one pin's words leaves every other pin's configuration unchanged.
- R11: `rsp_valid` is high for exactly the cycle after each read request. `rsp_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | {pin index, word select} |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin output data |
| pad_func | output | NUM_PINS*FUNC_W | Per-pin function index |
| pad_bias | output | NUM_PINS*2 | Per-pin raw bias code |
| pad_pull_up | output | NUM_PINS | Decoded pull-up request |
| pad_pull_dn | output | NUM_PINS | Decoded pull-down request |
| pad_keeper | output | NUM_PINS | Decoded keeper request |
| pad_drive | output | NUM_PINS*3 | Per-pin drive code |

## Verification
The hardest case to observe from the ports is the exact two-flop latency on the input path. A read returns a registered copy of an already-synchronized bit, so a wrong stage count hides unless reads land on consecutive edges. The bench changes `pad_in` and holds a read request of that pin's I/O word for three cycles in a row. It expects the old level twice and the new level on the third read. The keeper remap is checked by a second instance built with `NO_KEEPER`=1, which shares the first instance's bus, so every bias code is compared in both builds in the same cycle.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int DATA_W     = 32;
  localparam int FUNC_LSB   = 0;
  localparam int FUNC_MAX_W = 4;
  localparam int BIAS_LSB   = 4;
  localparam int DRV_LSB    = 8;
  localparam int OE_BIT     = 12;
  localparam int IO_IN_BIT  = 0;
  localparam int IO_OUT_BIT = 1;

  typedef struct packed {
    logic pull_up;
    logic pull_dn;
    logic keeper;
  } bias_req_t;

  function automatic bias_req_t bias_decode(input logic [1:0] code, input logic no_keep);
    bias_req_t r;
    r = '0;
    case (code)
      2'd1: r.pull_dn = 1'b1;
      2'd2: if (no_keep) r.pull_up = 1'b1; else r.keeper = 1'b1;
      2'd3: r.pull_up = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_mask(input int func_w);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < func_w; i++) m[FUNC_LSB+i] = 1'b1;
    m[BIAS_LSB +: 2] = 2'b11;
    m[DRV_LSB +: 3]  = 3'b111;
    m[OE_BIT]        = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_cfg_pkg::*;
#(
  parameter int FUNC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_io,
  input  logic [DATA_W-1:0] wdata,
  input  logic              in_lvl,
  output logic [FUNC_W-1:0] func,
  output logic [1:0]        bias,
  output logic [2:0]        drive,
  output logic              oe,
  output logic              out_lvl,
  output logic [DATA_W-1:0] ctl_word,
  output logic [DATA_W-1:0] io_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      func    <= '0;
      bias    <= '0;
      drive   <= '0;
      oe      <= 1'b0;
      out_lvl <= 1'b0;
    end else begin
      if (wr_ctl) begin
        func  <= wdata[FUNC_LSB +: FUNC_W];
        bias  <= wdata[BIAS_LSB +: 2];
        drive <= wdata[DRV_LSB +: 3];
        oe    <= wdata[OE_BIT];
      end
      if (wr_io) out_lvl <= wdata[IO_OUT_BIT];
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[FUNC_LSB +: FUNC_W] = func;
    ctl_word[BIAS_LSB +: 2]      = bias;
    ctl_word[DRV_LSB +: 3]       = drive;
    ctl_word[OE_BIT]             = oe;
    io_word = '0;
    io_word[IO_IN_BIT]  = in_lvl;
    io_word[IO_OUT_BIT] = out_lvl;
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS  = 4,
  parameter int FUNC_W    = 3,
  parameter bit NO_KEEPER = 1'b0,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W   = PIN_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [31:0]                req_wdata,
  output logic                       rsp_valid,
  output logic [31:0]                rsp_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS*FUNC_W-1:0] pad_func,
  output logic [NUM_PINS*2-1:0]      pad_bias,
  output logic [NUM_PINS-1:0]        pad_pull_up,
  output logic [NUM_PINS-1:0]        pad_pull_dn,
  output logic [NUM_PINS-1:0]        pad_keeper,
  output logic [NUM_PINS*3-1:0]      pad_drive
);
  logic [PIN_W-1:0]  pin_sel;
  logic              word_sel;
  logic              pin_ok;
  logic [NUM_PINS-1:0] in_sync;
  logic [DATA_W-1:0] ctl_words [NUM_PINS];
  logic [DATA_W-1:0] io_words  [NUM_PINS];
  logic [NUM_PINS-1:0] out_lvls;
  logic [DATA_W-1:0] rd_mux;

  assign pin_sel  = req_addr[ADDR_W-1:1];
  assign word_sel = req_addr[0];
  assign pin_ok   = int'(pin_sel) < NUM_PINS;

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(in_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic      hit;
    bias_req_t breq;
    assign hit = req_valid && req_write && pin_ok && (pin_sel == PIN_W'(p));

    gpio_pin_regs #(.FUNC_W(FUNC_W)) u_regs (
      .clk(clk), .rst(rst),
      .wr_ctl(hit && !word_sel),
      .wr_io(hit && word_sel),
      .wdata(req_wdata),
      .in_lvl(in_sync[p]),
      .func(pad_func[p*FUNC_W +: FUNC_W]),
      .bias(pad_bias[p*2 +: 2]),
      .drive(pad_drive[p*3 +: 3]),
      .oe(pad_oe[p]),
      .out_lvl(out_lvls[p]),
      .ctl_word(ctl_words[p]),
      .io_word(io_words[p])
    );

    assign pad_out[p]     = out_lvls[p] & pad_oe[p];
    assign breq           = bias_decode(pad_bias[p*2 +: 2], NO_KEEPER);
    assign pad_pull_up[p] = breq.pull_up;
    assign pad_pull_dn[p] = breq.pull_dn;
    assign pad_keeper[p]  = breq.keeper;
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_ok && pin_sel == PIN_W'(p))
        rd_mux = word_sel ? io_words[p] : ctl_words[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS  = 4,
  parameter int FUNC_W    = 3,
  parameter bit NO_KEEPER = 1'b0,
  parameter int PIN_W     = 2,
  parameter int ADDR_W    = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [31:0]                req_wdata,
  input logic                       rsp_valid,
  input logic [31:0]                rsp_rdata,
  input logic [NUM_PINS-1:0]        pad_oe,
  input logic [NUM_PINS-1:0]        pad_out,
  input logic [NUM_PINS*FUNC_W-1:0] pad_func,
  input logic [NUM_PINS*2-1:0]      pad_bias,
  input logic [NUM_PINS-1:0]        pad_pull_up,
  input logic [NUM_PINS-1:0]        pad_pull_dn,
  input logic [NUM_PINS-1:0]        pad_keeper,
  input logic [NUM_PINS*3-1:0]      pad_drive
);
  localparam logic [31:0] MASK = ctl_mask(FUNC_W);
  logic rd_req;
  assign rd_req = req_valid && !req_write;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_func == '0 && pad_bias == '0 && pad_drive == '0)); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_req && !req_addr[0]) |-> ((rsp_rdata & ~MASK) == '0)); // R3

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid); // R11

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_req) |-> $stable(rsp_rdata)); // R11

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    AST_TRISTATE: assert property (@(posedge clk) disable iff (rst)
      !pad_oe[p] |-> !pad_out[p]); // R7

    AST_BIAS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({pad_pull_up[p], pad_pull_dn[p], pad_keeper[p]})); // R4

    AST_NO_KEEPER: assert property (@(posedge clk) disable iff (rst)
      NO_KEEPER |-> !pad_keeper[p]); // R5

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_write && !req_addr[0] && req_addr[ADDR_W-1:1] == PIN_W'(p))
      |=> (pad_oe[p] == $past(req_wdata[OE_BIT]) &&
           pad_drive[p*3 +: 3] == $past(req_wdata[DRV_LSB +: 3]))); // R2
  end
endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(
  .NUM_PINS(NUM_PINS), .FUNC_W(FUNC_W), .NO_KEEPER(NO_KEEPER),
  .PIN_W(PIN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .pad_oe(pad_oe), .pad_out(pad_out),
  .pad_func(pad_func), .pad_bias(pad_bias), .pad_pull_up(pad_pull_up),
  .pad_pull_dn(pad_pull_dn), .pad_keeper(pad_keeper), .pad_drive(pad_drive)
);

// File: tb/test_gpio_cfg_bank.sv
module test_gpio_cfg_bank;
  localparam int NP = 4;
  localparam int FW = 3;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NP-1:0] pad_in = '0;

  logic rsp_valid, rsp_valid_nk;
  logic [31:0] rsp_rdata, rsp_rdata_nk;
  logic [NP-1:0] pad_oe, pad_out, pu, pd, kp;
  logic [NP-1:0] pad_oe_nk, pad_out_nk, pu_nk, pd_nk, kp_nk;
  logic [NP*FW-1:0] pad_func, pad_func_nk;
  logic [NP*2-1:0] pad_bias, pad_bias_nk;
  logic [NP*3-1:0] pad_drive, pad_drive_nk;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gpio_cfg_bank #(.NUM_PINS(NP), .FUNC_W(FW), .NO_KEEPER(1'b0)) i_gpio_cfg_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_func(pad_func), .pad_bias(pad_bias), .pad_pull_up(pu),
    .pad_pull_dn(pd), .pad_keeper(kp), .pad_drive(pad_drive));

  gpio_cfg_bank #(.NUM_PINS(NP), .FUNC_W(FW), .NO_KEEPER(1'b1)) i_gpio_cfg_bank_nk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid_nk),
    .rsp_rdata(rsp_rdata_nk), .pad_in(pad_in), .pad_oe(pad_oe_nk), .pad_out(pad_out_nk),
    .pad_func(pad_func_nk), .pad_bias(pad_bias_nk), .pad_pull_up(pu_nk),
    .pad_pull_dn(pd_nk), .pad_keeper(kp_nk), .pad_drive(pad_drive_nk));

  function automatic logic [31:0] ctl(input int f, input int b, input int d, input int o);
    return (32'(f) & 32'h7) | ((32'(b) & 32'h3) << 4) | ((32'(d) & 32'h7) << 8) | ((32'(o) & 32'h1) << 12);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int pin, input logic word, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = {2'(pin), word}; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input int pin, input logic word, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {2'(pin), word};
    @(negedge clk);
    req_valid = 1'b0;
    data = rsp_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      bus_read(p, 1'b0, d);
      chk(d == 32'h0, "R1 ctl word", d, 32'h0);
      bus_read(p, 1'b1, d);
      chk(d == 32'h0, "R1 io word", d, 32'h0);
    end
    chk(pad_oe == '0 && pad_out == '0, "R1 pad dir", {28'h0, pad_oe}, 32'h0);
    chk(pad_func == '0 && pad_bias == '0 && pad_drive == '0, "R1 pad fields",
        {8'h0, pad_drive, pad_func}, 32'h0);
  endtask

  task automatic t_ctl_fields;
    logic [31:0] d;
    logic [31:0] exp;
    exp = ctl(5, 1, 6, 1);
    bus_write(1, 1'b0, exp | 32'hFFFF_E8C8);
    chk(pad_func[1*FW +: FW] == 3'd5, "R2 func", 32'(pad_func[1*FW +: FW]), 32'd5);
    chk(pad_bias[2 +: 2] == 2'd1, "R2 bias", 32'(pad_bias[2 +: 2]), 32'd1);
    chk(pad_drive[3 +: 3] == 3'd6, "R2 drive", 32'(pad_drive[3 +: 3]), 32'd6);
    chk(pad_oe[1] == 1'b1, "R2 oe", 32'(pad_oe[1]), 32'd1);
    bus_read(1, 1'b0, d);
    chk(d == exp, "R2 R3 readback", d, exp);
    bus_read(0, 1'b0, d);
    chk(d == 32'h0, "R10 pin0 untouched", d, 32'h0);
    bus_read(2, 1'b0, d);
    chk(d == 32'h0, "R10 pin2 untouched", d, 32'h0);
    chk(pad_oe[0] == 1'b0 && pad_oe[2] == 1'b0, "R10 other oe", {28'h0, pad_oe}, 32'h2);
  endtask

  task automatic t_bias;
    for (int b = 0; b < 4; b++) begin
      logic [2:0] e, enk;
      bus_write(2, 1'b0, ctl(0, b, 0, 0));
      e   = (b == 3) ? 3'b100 : (b == 2) ? 3'b001 : (b == 1) ? 3'b010 : 3'b000;
      enk = (b >= 2) ? 3'b100 : (b == 1) ? 3'b010 : 3'b000;
      chk({pu[2], pd[2], kp[2]} == e, "R4 bias decode", 32'({pu[2], pd[2], kp[2]}), 32'(e));
      chk({pu_nk[2], pd_nk[2], kp_nk[2]} == enk, "R5 no-keeper decode",
          32'({pu_nk[2], pd_nk[2], kp_nk[2]}), 32'(enk));
    end
    chk(pad_drive[3 +: 3] == 3'd6, "R10 pin1 drive kept", 32'(pad_drive[3 +: 3]), 32'd6);
  endtask

  task automatic t_drive;
    for (int n = 0; n < 8; n++) begin
      bus_write(3, 1'b0, ctl(0, 0, n, 0));
      chk(pad_drive[9 +: 3] == 3'(n), "R6 drive code", 32'(pad_drive[9 +: 3]), 32'(n));
    end
  endtask

  task automatic t_outen;
    logic [31:0] d;
    bus_write(0, 1'b1, 32'h2);
    chk(pad_out[0] == 1'b0 && pad_oe[0] == 1'b0, "R7 tristate", {30'h0, pad_oe[0], pad_out[0]}, 32'h0);
    bus_read(0, 1'b1, d);
    chk(d == 32'h2, "R8 out level readback", d, 32'h2);
    bus_write(0, 1'b0, ctl(0, 0, 0, 1));
    chk(pad_out[0] == 1'b1 && pad_oe[0] == 1'b1, "R7 driving", {30'h0, pad_oe[0], pad_out[0]}, 32'h3);
    bus_write(0, 1'b1, 32'h0);
    chk(pad_out[0] == 1'b0, "R7 drive low", 32'(pad_out[0]), 32'h0);
  endtask

  task automatic t_io_ro;
    logic [31:0] d;
    bus_write(3, 1'b1, 32'hFFFF_FFFD);
    bus_read(3, 1'b1, d);
    chk(d == 32'h0, "R8 input bit read-only", d, 32'h0);
  endtask

  task automatic t_sync;
    logic [31:0] r1, r2, r3;
    @(negedge clk);
    pad_in[2] = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = {2'd2, 1'b1};
    @(negedge clk); r1 = rsp_rdata;
    @(negedge clk); r2 = rsp_rdata;
    @(negedge clk); r3 = rsp_rdata;
    req_valid = 1'b0;
    chk(r1[0] == 1'b0, "R9 edge k", r1, 32'h0);
    chk(r2[0] == 1'b0, "R9 edge k+1", r2, 32'h0);
    chk(r3[0] == 1'b1, "R9 edge k+2", r3, 32'h1);
  endtask

  task automatic t_resp;
    logic [31:0] d;
    bus_read(1, 1'b0, d);
    chk(rsp_valid == 1'b1, "R11 valid pulse", 32'(rsp_valid), 32'h1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 valid drops", 32'(rsp_valid), 32'h0);
    chk(rsp_rdata == ctl(5, 1, 6, 1), "R11 data held", rsp_rdata, ctl(5, 1, 6, 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_ctl_fields();
    t_bias();
    t_drive();
    t_outen();
    t_io_ro();
    t_sync();
    t_resp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule